// File: doc/BRIEF.md
# Three-slow second-order recursive filter

This block is a second-order recursive (IIR) filter in direct-form-II structure, in 16-bit Q1.15 fixed point. It has been rebuilt as a 3-slow design. Each delay element of the single-rate filter is replaced by three registers, so one datapath carries three independent sample streams interleaved in a fixed round-robin order. The datapath clock runs three times faster than the sample rate of any one stream, and that clock is synchronous with it. After the tripling, one of the three registers in the recursion loop has been moved into the loop. The multiply-accumulate of the feedback terms now sits in one register stage, and the input addition with saturation sits in the next.

Each input sample carries a 2-bit stream tag. A small state machine holds the slot it expects next. Its states are SLOT0, SLOT1 and SLOT2. The transitions are SLOT0→SLOT1, SLOT1→SLOT2 and SLOT2→SLOT0, and each one is taken only on an accepted sample. An accepted sample is one with the valid flag high and a tag equal to the expected slot. Any other input is discarded, and the state holds. A gap in the valid flag stalls the whole datapath, which keeps the three histories aligned.

Each stream behaves as its own filter. The intermediate state is w[n] = x[n] + 0.3513·w[n-1] + 0.3297·w[n-2]. The output is y[n] = 0.2180·w[n] − 0.0766·w[n-1] + 0.0719·w[n-2].

Top module: `iir3s_filter`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, out_valid is 0, out_tag is 0 and out_data is 0. All filter history is cleared to zero, so the first output of each stream after reset depends only on its own samples that follow the reset.
- R2: After reset the expected slot is 0. A sample is accepted only when in_valid is 1 and in_tag equals the expected slot. Each accepted sample moves the expected slot along the cycle 0, 1, 2, 0, and so on.
- R3: When in_valid is 0, or when in_tag differs from the expected slot (tag value 3 included), the input has no effect. No output is produced for it, the expected slot does not change, and no stream's history changes.
- R4: A sample accepted at clock edge k raises out_valid for exactly one cycle, after edge k+1. out_valid is never high at any other time.
- R5: out_tag equals the tag of the sample that produced the output, so it is always 0, 1 or 2.
- R6: For each stream, w = sat(x + ((11511·w1 + 10804·w2 + 16384) >> 15)). Here w1 and w2 are that stream's previous two w values, and >> is an arithmetic shift, which rounds the result half up.
- R7: out_data = sat((7143·w − 2510·w1 + 2356·w2 + 16384) >> 15). It uses the same w, w1 and w2 as R6, in Q1.15.
- R8: sat() clamps its argument to the range −32768 to 32767, so sustained full-scale inputs give outputs that are limited and do not wrap.
- R9: Each stream's output sequence equals that of a separate single-rate filter fed only with that stream's accepted samples. This holds whatever the gaps in the valid flag and whatever the samples of the other streams.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Datapath clock, three times the per-stream sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_tag | input | 2 | Stream index of the input sample |
| in_data | input | 16 | Input sample, signed Q1.15 |
| out_valid | output | 1 | Output sample present |
| out_tag | output | 2 | Stream index of the output sample |
| out_data | output | 16 | Filtered sample, signed Q1.15 |

## Verification
An impulse placed on a single stream must give a response only on that stream, with its taps spaced three accepted samples apart. A design that shared history between streams, or that tapped the delay line at the wrong spacing, would put echoes on the other tags. Sustained full-scale inputs of both signs drive the state into the clamp. A design that wrapped instead of clamping would flip the sign of its output there. Tags that arrive out of turn, and gaps in the valid flag, are mixed into random traffic. A design that advanced its slot or shifted its delay line on a discarded or idle cycle would put every later sample out of step with its stream. A second reset in mid-run shows whether any stale history survives.

// File: rtl/iir3s_pkg.sv
package iir3s_pkg;
    localparam int DATA_W = 16;                 // sample width, Q1.15
    localparam int FRAC   = DATA_W - 1;         // fractional bits
    localparam int NSLOT  = 3;                  // C-slow factor
    localparam int TAG_W  = $clog2(NSLOT);
    localparam int TAPS   = 2 * NSLOT + 1;      // w now, w one and two stream-steps back
    localparam int ACC_W  = 2 * DATA_W + 2;     // product sum width
    localparam int MID_W  = ACC_W - FRAC;       // width after the rounding shift

    // Q1.15 coefficients: round(c * 2^15)
    localparam logic signed [DATA_W-1:0] CF_A1 = 16'sd11511;  //  0.3513
    localparam logic signed [DATA_W-1:0] CF_A2 = 16'sd10804;  //  0.3297
    localparam logic signed [DATA_W-1:0] CF_B0 = 16'sd7143;   //  0.2180
    localparam logic signed [DATA_W-1:0] CF_B1 = -16'sd2510;  // -0.0766
    localparam logic signed [DATA_W-1:0] CF_B2 = 16'sd2356;   //  0.0719

    localparam logic signed [MID_W-1:0] SAT_HI = MID_W'(2 ** (DATA_W - 1) - 1);
    localparam logic signed [MID_W-1:0] SAT_LO = -MID_W'(2 ** (DATA_W - 1));

    function automatic logic signed [ACC_W-1:0] prod(input logic signed [DATA_W-1:0] c,
                                                     input logic signed [DATA_W-1:0] v);
        return ACC_W'(c) * ACC_W'(v);
    endfunction

    function automatic logic signed [MID_W-1:0] round_q(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] t;
        t = v + ACC_W'(1 << (FRAC - 1));
        return t[ACC_W-1:FRAC];
    endfunction

    function automatic logic signed [DATA_W-1:0] sat_q(input logic signed [MID_W-1:0] v);
        logic signed [MID_W-1:0] t;
        if (v > SAT_HI)      t = SAT_HI;
        else if (v < SAT_LO) t = SAT_LO;
        else                 t = v;
        return t[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/iir3s_slot_fsm.sv
module iir3s_slot_fsm
    import iir3s_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    output logic             accept,
    output logic [TAG_W-1:0] slot
);
    typedef enum logic [TAG_W-1:0] {SLOT0 = 2'd0, SLOT1 = 2'd1, SLOT2 = 2'd2} slot_e;

    slot_e state_q, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT0;
        else        state_q <= state_nx;
    end

    always_comb begin
        accept   = in_valid && (in_tag == state_q);
        state_nx = state_q;
        if (accept) begin
            unique case (state_q)
                SLOT0:   state_nx = SLOT1;
                SLOT1:   state_nx = SLOT2;
                SLOT2:   state_nx = SLOT0;
                default: state_nx = SLOT0;
            endcase
        end
        slot = state_q;
    end
endmodule

// File: rtl/iir3s_recur.sv
module iir3s_recur
    import iir3s_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     accept,
    input  logic signed [DATA_W-1:0] x_in,
    output logic signed [DATA_W-1:0] w_now,
    output logic signed [DATA_W-1:0] w_back1,
    output logic signed [DATA_W-1:0] w_back2
);
    // Tap of the delay line that the feedback stage reads one step early (retimed loop).
    localparam int FB_T1 = NSLOT - 2;
    localparam int FB_T2 = 2 * NSLOT - 2;

    logic signed [DATA_W-1:0] wd [TAPS];
    logic signed [MID_W-1:0]  fb_q;
    logic signed [DATA_W-1:0] w_new;

    always_comb w_new = sat_q(MID_W'(x_in) + fb_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_q <= '0;
            for (int i = 0; i < TAPS; i++) wd[i] <= '0;
        end else if (accept) begin
            fb_q  <= round_q(prod(CF_A1, wd[FB_T1]) + prod(CF_A2, wd[FB_T2]));
            wd[0] <= w_new;
            for (int i = 1; i < TAPS; i++) wd[i] <= wd[i-1];
        end
    end

    assign w_now   = wd[0];
    assign w_back1 = wd[NSLOT];
    assign w_back2 = wd[2*NSLOT];
endmodule

// File: rtl/iir3s_ffwd.sv
module iir3s_ffwd
    import iir3s_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fire,
    input  logic [TAG_W-1:0]         tag_in,
    input  logic signed [DATA_W-1:0] w_now,
    input  logic signed [DATA_W-1:0] w_back1,
    input  logic signed [DATA_W-1:0] w_back2,
    output logic                     out_valid,
    output logic [TAG_W-1:0]         out_tag,
    output logic signed [DATA_W-1:0] out_data
);
    logic signed [DATA_W-1:0] y_c;

    always_comb
        y_c = sat_q(round_q(prod(CF_B0, w_now) + prod(CF_B1, w_back1) + prod(CF_B2, w_back2)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tag   <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_tag  <= tag_in;
                out_data <= y_c;
            end
        end
    end
endmodule

// File: rtl/iir3s_filter.sv
module iir3s_filter
    import iir3s_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [TAG_W-1:0]         in_tag,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic [TAG_W-1:0]         out_tag,
    output logic signed [DATA_W-1:0] out_data
);
    logic             accept;
    logic [TAG_W-1:0] slot;
    logic             fire_q;
    logic [TAG_W-1:0] tag_q;
    logic signed [DATA_W-1:0] w_now, w_back1, w_back2;

    iir3s_slot_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
        .accept(accept), .slot(slot)
    );

    iir3s_recur u_recur (
        .clk(clk), .rst_n(rst_n), .accept(accept), .x_in(in_data),
        .w_now(w_now), .w_back1(w_back1), .w_back2(w_back2)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_q <= 1'b0;
            tag_q  <= '0;
        end else begin
            fire_q <= accept;
            if (accept) tag_q <= in_tag;
        end
    end

    iir3s_ffwd u_ffwd (
        .clk(clk), .rst_n(rst_n), .fire(fire_q), .tag_in(tag_q),
        .w_now(w_now), .w_back1(w_back1), .w_back2(w_back2),
        .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data)
    );
endmodule

// File: rtl/iir3s_filter_chk.sv
module iir3s_filter_chk
    import iir3s_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [TAG_W-1:0] in_tag,
    input logic             accept,
    input logic [TAG_W-1:0] slot,
    input logic             out_valid,
    input logic [TAG_W-1:0] out_tag
);
    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 out_valid); // R4
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(accept, 2)); // R4
    AST_TAG_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_tag == $past(in_tag, 2))); // R5
    AST_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_tag < TAG_W'(NSLOT))); // R5
    AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (slot != $past(slot))); // R2
    AST_IGNORED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || (in_tag != slot)) |=> $stable(slot)); // R3
endmodule

bind iir3s_filter iir3s_filter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .accept(accept), .slot(slot), .out_valid(out_valid), .out_tag(out_tag)
);

// File: tb/sim_iir3s_filter.sv
module sim_iir3s_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_tag = 2'd0;
    logic signed [15:0] in_data = '0;
    logic        out_valid;
    logic [1:0]  out_tag;
    logic signed [15:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    iir3s_filter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag), .in_data(in_data),
        .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data)
    );

    // bench model: one single-rate filter per stream
    longint mw1 [3];
    longint mw2 [3];
    int     eslot;
    bit     pv0, pv1;
    int     pt0, pt1;
    longint py0, py1;

    function automatic longint sat(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint model_step(input int s, input longint x);
        longint w, y;
        w = sat(x + ((11511 * mw1[s] + 10804 * mw2[s] + 16384) >>> 15));          // R6 R8
        y = sat((7143 * w - 2510 * mw1[s] + 2356 * mw2[s] + 16384) >>> 15);       // R7 R8
        mw2[s] = mw1[s];
        mw1[s] = w;
        return y;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input int tg, input longint x, input string req);
        bit acc;
        @(negedge clk);
        check(out_valid == pv1, "R4", "out_valid", longint'(out_valid), longint'(pv1));
        if (pv1 && out_valid) begin
            check(int'(out_tag) == pt1, "R5", "out_tag", longint'(out_tag), longint'(pt1));
            check(longint'(out_data) == py1, req, "out_data", longint'(out_data), py1);
        end
        pv1 = pv0; pt1 = pt0; py1 = py0;
        in_valid = v;
        in_tag   = 2'(tg);
        in_data  = 16'(x);
        acc = v && (tg == eslot);
        pv0 = acc;
        if (acc) begin
            pt0 = tg;
            py0 = model_step(tg, x);
            eslot = (eslot + 1) % 3;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; in_tag = 2'd0; in_data = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
        check(out_data == 16'sd0, "R1", "out_data in reset", longint'(out_data), 0);
        check(out_tag == 2'd0, "R1", "out_tag in reset", longint'(out_tag), 0);
        for (int s = 0; s < 3; s++) begin mw1[s] = 0; mw2[s] = 0; end
        eslot = 0; pv0 = 0; pv1 = 0; pt0 = 0; pt1 = 0; py0 = 0; py1 = 0;
        rst_n = 1'b1;
    endtask

    task automatic round3(input longint x0, input longint x1, input longint x2, input string req);
        step(1, 0, x0, req);
        step(1, 1, x1, req);
        step(1, 2, x2, req);
    endtask

    task automatic flush();
        repeat (3) step(0, 0, 0, "R4");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R1: first cycle after release still idle
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after release", longint'(out_valid), 0);
        check(out_data == 16'sd0, "R1", "out_data after release", longint'(out_data), 0);

        // R9 / R6 / R7: impulse on stream 0 only; streams 1 and 2 must stay zero
        round3(16384, 0, 0, "R9");
        repeat (6) round3(0, 0, 0, "R9");
        flush();

        // R3: wrong tags and idle cycles are discarded
        step(1, 2, 9999, "R3");
        step(1, 3, -9999, "R3");
        step(0, 0, 12345, "R3");
        step(1, 1, 5000, "R3");
        round3(-3000, 7000, 100, "R3");
        round3(0, 0, 0, "R3");

        // R2: the tag order continues after a stall of several cycles
        step(1, 0, 2000, "R2");
        repeat (4) step(0, 1, 0, "R2");
        step(1, 1, -2000, "R2");
        step(0, 2, 0, "R2");
        step(1, 2, 31000, "R2");
        flush();

        // R8: sustained full scale of both signs
        repeat (10) round3(100, 32767, -32768, "R8");
        repeat (4) round3(-32768, 32767, 0, "R8");
        flush();

        // R9: constrained random traffic with gaps and out-of-turn tags
        for (int i = 0; i < 3000; i++) begin
            int r, tg;
            longint x;
            bit v;
            r = int'($urandom % 100);
            v = (r < 80);
            tg = (r < 8) ? int'(($urandom % 4)) : eslot;
            if ($urandom % 10 == 0) x = ($urandom % 2) ? 32767 : -32768;
            else x = longint'($signed(16'($urandom)));
            step(v, tg, x, "R9");
        end
        flush();

        // R1: mid-run reset clears every stream's history
        do_reset();
        round3(0, 20000, 0, "R1");
        repeat (3) round3(0, 0, 0, "R1");
        flush();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule